// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Counter

This block keeps the remaining-transfer count for each of six DMA channels. Software loads each channel's 8-bit counter over a byte-wide register port, and it can read the live remaining value back at any time. The DMA controller raises a per-channel completion strobe after each transfer, together with that channel's transfer width. The counter then steps down by 1 for a byte transfer or by 2 for a 16-bit transfer.

A channel finishes when a decrement borrows past zero, not when the count reaches zero. Software therefore loads the transfer count minus one for byte transfers, and twice that value for 16-bit transfers. In 16-bit mode bit 0 takes no part in counting or in borrow detection. When a borrow happens, the channel raises a one-cycle terminal-count pulse and the counter keeps the wrapped value.

Top module: `dma_xfer_counter`

## Requirements
- R1: A register write with `reg_addr_i` in 0..5 loads `reg_wdata_i` into that channel's counter. From the following cycle, `reg_rdata_o` shows the new value while the same address is applied.
- R2: A completion strobe with width select 0 (byte) decrements that channel's counter by 1, modulo 256.
- R3: A completion strobe with width select 1 (16-bit) decrements that channel's counter by 2, modulo 256. Bit 0 of the counter is left unchanged.
- R4: In byte mode, a strobe on a count of 0x00 raises that channel's `tc_o` bit for exactly one cycle after the clock edge that takes the strobe, and the counter becomes 0xFF.
- R5: In 16-bit mode, a strobe on a count whose bits 7:1 are all zero (0x00 or 0x01) raises that channel's `tc_o` bit for one cycle. The counter wraps to 0xFE or 0xFF respectively.
- R6: A strobe that does not borrow leaves `tc_o` low for that channel.
- R7: A register write and a strobe to the same channel in the same cycle load the written value. The decrement is dropped and no terminal count is raised.
- R8: Strobes to several channels in the same cycle, each with its own width, update every channel independently.
- R9: A write to address 6 or 7 changes no counter, and a read of address 6 or 7 returns 0x00.
- R10: While `rst_ni` is low, `tc_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Channel select for register read and write |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Counter of the selected channel (0 when out of range) |
| done_i | input | 6 | Per-channel transfer-complete strobe |
| wide_i | input | 6 | Per-channel width select: 0 byte, 1 16-bit |
| tc_o | output | 6 | Per-channel terminal-count pulse |

## Verification
The bench sweeps every 8-bit starting value through one strobe in both widths, and compares the result against arithmetic modulo 256. A design that detected the end on reaching zero, or that tested bit 0 in 16-bit mode, would pulse terminal count one step early or late at 0x01 or 0x02. A design that stepped by 1 in 16-bit mode would disturb bit 0. The bench also targets a write and a strobe to the same channel in one cycle, where a wrong priority leaves a decremented value or a spurious pulse. It drives mixed-width strobes to all channels at once, where shared logic would cross-couple channels. It checks out-of-range addresses, where a loose decoder would corrupt a channel.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_HALF = 1'b1
  } xfer_size_e;

  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned NUM_CH_DEF = 6;
endpackage

// File: rtl/dma_cnt_decode.sv
module dma_cnt_decode #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ch_we_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ch_we_o[i] = we_i && (addr_i == ADDR_W'(i));
  end

  p_we_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we_o));
  p_no_we_oob_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) >= NUM_CH) |-> (ch_we_o == '0));
endmodule

// File: rtl/dma_cnt_channel.sv
module dma_cnt_channel
  import dma_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             done_i,
  input  xfer_size_e       size_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc_q, tc_d;
  logic             borrow;
  logic [CNT_W-1:0] step;

  // 16-bit mode: bit 0 is outside the borrow test and untouched by a step of 2
  always_comb begin
    if (size_i == XFER_HALF) begin
      borrow = (cnt_q[CNT_W-1:1] == '0);
      step   = CNT_W'(2);
    end else begin
      borrow = (cnt_q == '0);
      step   = CNT_W'(1);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    tc_d  = 1'b0;
    if (wr_i) begin
      cnt_d = wdata_i;
    end else if (done_i) begin
      cnt_d = cnt_q - step;
      tc_d  = borrow;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
  p_byte_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_i && size_i == XFER_BYTE) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_half_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_i && size_i == XFER_HALF) |=> (cnt_q[0] == $past(cnt_q[0])));
  p_tc_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> !tc_q);
  p_tc_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_q) |-> ($past(done_i) && !$past(wr_i)));
  p_wr_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && done_i) |=> !tc_q);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !done_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_cnt_rdmux.sv
module dma_cnt_rdmux #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0]             rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = cnt_i[i];
    end
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dma_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] wide_i,
  output logic [NUM_CH-1:0] tc_o
);
  logic [NUM_CH-1:0]            ch_we;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt;

  dma_cnt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .ch_we_o (ch_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_cnt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_we[i]),
      .wdata_i (reg_wdata_i),
      .done_i  (done_i[i]),
      .size_i  (xfer_size_e'(wide_i[i])),
      .cnt_o   (cnt[i]),
      .tc_o    (tc_o[i])
    );
  end

  dma_cnt_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i  (reg_addr_i),
    .cnt_i   (cnt),
    .rdata_o (reg_rdata_o)
  );

  p_tc_needs_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tc_o & ~$past(done_i)) == '0));
  p_oob_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(reg_addr_i) >= NUM_CH) |-> (reg_rdata_o == '0));
endmodule

// File: tb/dma_xfer_counter_tb.sv
module dma_xfer_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] done = '0;
  logic [5:0] wide = '0;
  logic [5:0] tc;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_xfer_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_i(done),
    .wide_i(wide), .tc_o(tc)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    addr = 3'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic strobe(logic [5:0] m, logic [5:0] w);
    @(negedge clk);
    done = m; wide = w;
    @(negedge clk);
    done = '0; wide = '0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    int exp_cnt;
    int exp_tc;
    int vals[6];
    #20;
    check("R10 tc in reset", int'(tc), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      wr(i, 8'h30 + i * 8'h11);
      rd(i, v);
      check("R1 load readback", v, 8'h30 + i * 8'h11);
    end

    for (int s = 0; s < 256; s++) begin
      wr(1, s);
      strobe(6'b000010, 6'b000000);
      exp_cnt = (s - 1) & 8'hFF;
      exp_tc = (s == 0) ? 2 : 0;
      check(s == 0 ? "R4 byte borrow tc" : "R6 byte no tc", int'(tc), exp_tc);
      rd(1, v);
      check(s == 0 ? "R4 byte wrap" : "R2 byte step", v, exp_cnt);
      @(negedge clk);
      check("R4 tc one cycle", int'(tc), 0);
    end

    for (int s = 0; s < 256; s++) begin
      wr(4, s);
      strobe(6'b010000, 6'b010000);
      exp_cnt = (s - 2) & 8'hFF;
      exp_tc = ((s >> 1) == 0) ? 16 : 0;
      check((s >> 1) == 0 ? "R5 half borrow tc" : "R6 half no tc", int'(tc), exp_tc);
      rd(4, v);
      check((s >> 1) == 0 ? "R5 half wrap" : "R3 half step", v, exp_cnt);
    end

    // R7 write beats decrement on the same channel
    wr(2, 8'h00);
    @(negedge clk);
    addr = 3'd2; wdata = 8'h00; we = 1'b1; done = 6'b000100;
    @(negedge clk);
    we = 1'b0; done = '0;
    check("R7 no tc on collision", int'(tc), 0);
    rd(2, v);
    check("R7 write wins", v, 8'h00);

    // R8 mixed-width strobes on all channels
    for (int i = 0; i < 6; i++) begin
      vals[i] = (i * 8'h2B + 1) & 8'hFF;
      if (i == 3) vals[i] = 8'h01;
      if (i == 0) vals[i] = 8'h00;
      wr(i, vals[i]);
    end
    strobe(6'b111111, 6'b101010);
    exp_tc = 0;
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 1) begin
        if ((vals[i] >> 1) == 0) exp_tc |= (1 << i);
      end else begin
        if (vals[i] == 0) exp_tc |= (1 << i);
      end
    end
    check("R8 tc vector", int'(tc), exp_tc);
    for (int i = 0; i < 6; i++) begin
      rd(i, v);
      check("R8 independent count", v, (vals[i] - ((i % 2 == 1) ? 2 : 1)) & 8'hFF);
      vals[i] = v;
    end

    // R9 out-of-range addresses
    wr(6, 8'hA5);
    wr(7, 8'h5A);
    rd(6, v);
    check("R9 oob read 6", v, 0);
    rd(7, v);
    check("R9 oob read 7", v, 0);
    for (int i = 0; i < 6; i++) begin
      rd(i, v);
      check("R9 channels untouched", v, vals[i]);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule